// File: doc/BRIEF.md
# Interleaved Multiphase PWM Phase Generator

This block generates up to six staggered pulse-width-modulated carrier signals for a multiphase power-converter controller. A single free-running period counter, `PERIOD` clock cycles long, is shared by every phase. Each phase compares the counter, shifted by its own offset, against a common duty word. Several devices can run in parallel and interleave their phases. Each device reads its position in the group and the group size from board straps, so all phases of all devices end up evenly spread over one period.

The straps are read once, on the first clock after reset is released, and are held until the next reset. Three strap groups are read:
- the levels seen on the third through sixth PWM pins, which select the active phase count;
- a 2-bit encoded address level, which selects master or one of three slave positions;
- a 2-bit slave-count code.

A slave device releases the shared sync, drive-enable and phase-drop lines so that they act as inputs. It also flags its local regulation functions as disabled.

A controller FSM has three states:
- **Sample**: the reset state. Straps are captured here and the role outputs are inactive.
- **Idle**: the counter is held at 0 and the outputs are low.
- **Run**: the counter advances and the outputs toggle.

It has four transitions:
- Sample→Run if enable is high at the first clock after reset.
- Sample→Idle otherwise.
- Idle→Run when enable is high.
- Run→Idle when enable is low.

Top module: `pwm_phase_gen`

## Requirements
- R1: Straps are captured only on the first clock after reset release. Later changes on any strap input alter neither the PWM pattern nor the role outputs.
- R2: The phase count N is chosen from `phase_strap_i` by priority. Bit 0 high gives 2. Otherwise bit 1 high gives 3. Otherwise bit 2 or bit 3 high gives 4. All four bits low gives 6.
- R3: `addr_strap_i` sets the device order d: 00 is the master (d=0), 11 is slave-1 (d=1), 01 is slave-2 (d=2) and 10 is slave-3 (d=3).
- R4: `count_strap_i` gives the slave count S: 00 is 1, 11 is 2, 10 (bit 0 low, bit 1 high) is 3, and 01 is 0. The device total is M = max(S+1, d+1).
- R5: The counter runs from 0 to `PERIOD`-1 and wraps. Phase k has offset off_k = (d + k·M)·(`PERIOD`/(N·M)). In the cycle after the counter holds c, `pwm_o[k]` is high exactly when (c − off_k) mod `PERIOD` < `duty_i`.
- R6: Every `pwm_o[k]` with k ≥ N is held low.
- R7: While `en_i` is low, all of `pwm_o` is low in that same cycle. A new enable restarts the counter from 0.
- R8: Until the straps are captured, `is_master_o`, `sync_oe_o`, `drv_oe_o` and `pdrop_oe_o` are low and `reg_off_o` is high. After capture, a master drives the first four high and `reg_off_o` low. A slave does the opposite.
- R9: A duty of 0 keeps every phase low. A duty of at least `PERIOD` keeps every active phase continuously high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable |
| duty_i | input | DUTY_W | High time in counter cycles |
| phase_strap_i | input | 4 | Levels on PWM pins 3..6 (bit 0 = pin 3) |
| addr_strap_i | input | 2 | Encoded address level |
| count_strap_i | input | 2 | Slave-count code |
| pwm_o | output | 6 | Per-phase PWM outputs |
| is_master_o | output | 1 | Device is the master |
| sync_oe_o | output | 1 | Drive the shared sync line |
| drv_oe_o | output | 1 | Drive the shared drive-enable line |
| pdrop_oe_o | output | 1 | Drive the shared phase-drop line |
| reg_off_o | output | 1 | Local regulation functions disabled |

## Verification
Directed scenarios cover a range of strap combinations. In each, every output bit is compared in every cycle of two full periods against a model built from the offset formula.

A wrong captured configuration appears at the ports in two ways:
- A bad phase count or device order shifts or masks edges within the first period after enable.
- A bad role appears on the role outputs in the first cycle after capture.

A counter that fails to restart, or straps that are re-read, show up as a pattern mismatch on the next enabled run.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_IDLE   = 2'd1,
        ST_RUN    = 2'd2
    } gen_state_t;

    typedef struct packed {
        logic       master;
        logic [1:0] order;
        logic [2:0] nph;
        logic [2:0] ndev;
    } strap_cfg_t;

    localparam int MAX_PH = 6;

endpackage

// File: rtl/strap_decoder.sv
module strap_decoder
    import pwm_phase_pkg::*;
(
    input  logic [3:0]  phase_strap_i,
    input  logic [1:0]  addr_strap_i,
    input  logic [1:0]  count_strap_i,
    output strap_cfg_t  cfg_o
);
    logic [2:0] slaves;
    logic [2:0] by_slaves;
    logic [2:0] by_order;

    always_comb begin
        // phase count: lowest strapped pin wins
        if (phase_strap_i[0])                         cfg_o.nph = 3'd2;
        else if (phase_strap_i[1])                    cfg_o.nph = 3'd3;
        else if (phase_strap_i[2] || phase_strap_i[3]) cfg_o.nph = 3'd4;
        else                                          cfg_o.nph = 3'd6;

        unique case (addr_strap_i)
            2'b00: cfg_o.order = 2'd0;
            2'b11: cfg_o.order = 2'd1;
            2'b01: cfg_o.order = 2'd2;
            2'b10: cfg_o.order = 2'd3;
        endcase
        cfg_o.master = (addr_strap_i == 2'b00);

        unique case (count_strap_i)
            2'b00: slaves = 3'd1;
            2'b11: slaves = 3'd2;
            2'b10: slaves = 3'd3;
            2'b01: slaves = 3'd0;
        endcase

        by_slaves = slaves + 3'd1;
        by_order  = {1'b0, cfg_o.order} + 3'd1;
        cfg_o.ndev = (by_slaves > by_order) ? by_slaves : by_order;
    end
endmodule

// File: rtl/phase_period_counter.sv
module phase_period_counter #(
    parameter int PERIOD = 144,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i)
            cnt_o <= '0;
        else if (cnt_o == CW'(PERIOD - 1))
            cnt_o <= '0;
        else
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/phase_slice.sv
module phase_slice #(
    parameter int PERIOD = 144,
    parameter int IDX    = 0,
    parameter int DUTY_W = 8,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic [CW-1:0]     cnt_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [CW-1:0]     step_i,
    input  logic [1:0]        order_i,
    input  logic [2:0]        ndev_i,
    input  logic [2:0]        nph_i,
    output logic              hit_o
);
    logic [4:0]    units;
    logic [CW-1:0] off;
    logic [CW:0]   pos;

    always_comb begin
        units = 5'(order_i) + 5'(IDX) * 5'(ndev_i);
        off   = CW'(units) * step_i;
        if (cnt_i >= off)
            pos = {1'b0, cnt_i - off};
        else
            pos = (CW+1)'(cnt_i) + (CW+1)'(PERIOD) - (CW+1)'(off);
        hit_o = (3'(IDX) < nph_i) && (32'(pos) < 32'(duty_i));
    end
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
    import pwm_phase_pkg::*;
#(
    parameter int PERIOD = 144,
    parameter int DUTY_W = $clog2(PERIOD + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [3:0]        phase_strap_i,
    input  logic [1:0]        addr_strap_i,
    input  logic [1:0]        count_strap_i,
    output logic [5:0]        pwm_o,
    output logic              is_master_o,
    output logic              sync_oe_o,
    output logic              drv_oe_o,
    output logic              pdrop_oe_o,
    output logic              reg_off_o
);
    localparam int CW = $clog2(PERIOD);

    gen_state_t        state_q, state_d;
    strap_cfg_t        cfg_dec, cfg_q;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     step;
    logic [5:0]        prod;
    logic [MAX_PH-1:0] hit, pwm_q;

    strap_decoder u_dec (
        .phase_strap_i (phase_strap_i),
        .addr_strap_i  (addr_strap_i),
        .count_strap_i (count_strap_i),
        .cfg_o         (cfg_dec)
    );

    // state register and capture
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_SAMPLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SAMPLE)
                cfg_q <= cfg_dec;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: state_d = en_i ? ST_RUN : ST_IDLE;
            ST_IDLE:   state_d = en_i ? ST_RUN : ST_IDLE;
            ST_RUN:    state_d = en_i ? ST_RUN : ST_IDLE;
            default:   state_d = ST_SAMPLE;
        endcase
    end

    phase_period_counter #(.PERIOD(PERIOD)) u_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .run_i (state_q == ST_RUN),
        .cnt_o (cnt)
    );

    // slot width = PERIOD / (N*M), each divisor a constant
    always_comb begin
        prod = 6'(cfg_q.nph) * 6'(cfg_q.ndev);
        case (prod)
            6'd2:    step = CW'(PERIOD / 2);
            6'd3:    step = CW'(PERIOD / 3);
            6'd4:    step = CW'(PERIOD / 4);
            6'd6:    step = CW'(PERIOD / 6);
            6'd8:    step = CW'(PERIOD / 8);
            6'd9:    step = CW'(PERIOD / 9);
            6'd12:   step = CW'(PERIOD / 12);
            6'd16:   step = CW'(PERIOD / 16);
            6'd18:   step = CW'(PERIOD / 18);
            default: step = CW'(PERIOD / 24);
        endcase
    end

    for (genvar k = 0; k < MAX_PH; k++) begin : g_phase
        phase_slice #(.PERIOD(PERIOD), .IDX(k), .DUTY_W(DUTY_W)) u_slice (
            .cnt_i   (cnt),
            .duty_i  (duty_i),
            .step_i  (step),
            .order_i (cfg_q.order),
            .ndev_i  (cfg_q.ndev),
            .nph_i   (cfg_q.nph),
            .hit_o   (hit[k])
        );
    end

    // output register
    always_ff @(posedge clk_i) begin
        if (rst_i)
            pwm_q <= '0;
        else
            pwm_q <= (state_q == ST_RUN) ? hit : '0;
    end

    always_comb begin
        pwm_o       = pwm_q & {MAX_PH{en_i}};
        is_master_o = cfg_q.master;
        sync_oe_o   = cfg_q.master;
        drv_oe_o    = cfg_q.master;
        pdrop_oe_o  = cfg_q.master;
        reg_off_o   = !cfg_q.master;
    end
endmodule

// File: rtl/pwm_phase_gen_chk.sv
module pwm_phase_gen_chk #(
    parameter int DUTY_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              en_i,
    input logic [DUTY_W-1:0] duty_i,
    input logic [5:0]        pwm_o,
    input logic              is_master_o,
    input logic              sync_oe_o,
    input logic              drv_oe_o,
    input logic              pdrop_oe_o,
    input logic              reg_off_o
);
    logic seen1, seen2;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seen1 <= 1'b0;
            seen2 <= 1'b0;
        end else begin
            seen1 <= 1'b1;
            seen2 <= seen1;
        end
    end

    assert_disabled_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |-> (pwm_o == '0));

    assert_zero_duty_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(duty_i) == '0) |-> (pwm_o == '0));

    assert_role_held_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        seen2 |-> $stable({is_master_o, sync_oe_o, drv_oe_o, pdrop_oe_o, reg_off_o}));

    assert_slave_release_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (sync_oe_o || drv_oe_o || pdrop_oe_o) |-> (is_master_o && !reg_off_o));
endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .en_i        (en_i),
    .duty_i      (duty_i),
    .pwm_o       (pwm_o),
    .is_master_o (is_master_o),
    .sync_oe_o   (sync_oe_o),
    .drv_oe_o    (drv_oe_o),
    .pdrop_oe_o  (pdrop_oe_o),
    .reg_off_o   (reg_off_o)
);

// File: tb/pwm_phase_gen_test.sv
module pwm_phase_gen_test;
    localparam int P  = 144;
    localparam int DW = $clog2(P + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [DW-1:0] duty = '0;
    logic [3:0]    ps = 4'b0001;
    logic [1:0]    as = 2'b00;
    logic [1:0]    cs = 2'b01;
    logic [5:0]    pwm;
    logic          mst, soe, doe, poe, roff;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_phase_gen #(.PERIOD(P)) uut (
        .clk_i(clk), .rst_i(rst), .en_i(en), .duty_i(duty),
        .phase_strap_i(ps), .addr_strap_i(as), .count_strap_i(cs),
        .pwm_o(pwm), .is_master_o(mst), .sync_oe_o(soe), .drv_oe_o(doe),
        .pdrop_oe_o(poe), .reg_off_o(roff)
    );

    function automatic logic [5:0] model(int n, int d, int m, int dt, int c);
        logic [5:0] r = '0;
        for (int k = 0; k < 6; k++) begin
            if (k < n) begin
                int off = (d + k * m) * (P / (n * m));
                int pos = (c - off + P) % P;
                r[k] = (pos < dt);
            end
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(logic [3:0] p, logic [1:0] a, logic [1:0] c);
        rst = 1'b1; en = 1'b0; ps = p; as = a; cs = c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: before capture all role outputs inactive
        check({mst, soe, doe, poe, roff, pwm} == {5'b00001, 6'b0}, "R8",
              "reset state", int'({mst, soe, doe, poe, roff, pwm}), int'({5'b00001, 6'b0}));
        rst = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic check_role(bit master, string req);
        @(negedge clk);
        check({mst, soe, doe, poe, roff} == {master, master, master, master, !master},
              req, "role outputs", int'({mst, soe, doe, poe, roff}),
              int'({master, master, master, master, !master}));
    endtask

    task automatic run_pattern(int n, int d, int m, int dt, string req);
        int bad = 0;
        logic [5:0] ge = '0, gx = '0;
        @(negedge clk);
        duty = DW'(dt);
        en = 1'b1;
        @(posedge clk);
        for (int j = 1; j <= 2 * P; j++) begin
            logic [5:0] e;
            @(posedge clk);
            @(negedge clk);
            e = model(n, d, m, dt, (j - 1) % P);
            if (pwm !== e) begin
                if (bad == 0) begin ge = pwm; gx = e; end
                bad++;
            end
        end
        check(bad == 0, req, "pwm pattern first mismatch", int'(ge), int'(gx));
        en = 1'b0;
        @(posedge clk);
    endtask

    // R2 R5 R6: master alone, two phases
    task automatic t_two_phase_master();
        do_reset(4'b0001, 2'b00, 2'b01);
        check_role(1'b1, "R8");
        run_pattern(2, 0, 1, 40, "R2 R5 R6 two-phase");
    endtask

    // R2: pin 3 wins over pin 4
    task automatic t_priority();
        do_reset(4'b0011, 2'b00, 2'b01);
        run_pattern(2, 0, 1, 100, "R2 priority");
        do_reset(4'b0110, 2'b00, 2'b00);
        run_pattern(3, 0, 2, 30, "R2 R4 three-phase master with one slave");
    endtask

    // R3 R4: slave positions
    task automatic t_slaves();
        do_reset(4'b0010, 2'b11, 2'b00);
        check_role(1'b0, "R8 R3");
        run_pattern(3, 1, 2, 50, "R3 R4 R5 slave-1");
        do_reset(4'b1000, 2'b01, 2'b11);
        run_pattern(4, 2, 3, 20, "R3 R4 R5 slave-2");
        do_reset(4'b0000, 2'b10, 2'b10);
        check_role(1'b0, "R8");
        run_pattern(6, 3, 4, 10, "R3 R4 R5 R6 slave-3 six-phase");
        do_reset(4'b0001, 2'b10, 2'b01);
        run_pattern(2, 3, 4, 60, "R4 device total from order");
    endtask

    // R9: duty limits
    task automatic t_duty_limits();
        do_reset(4'b0100, 2'b00, 2'b01);
        run_pattern(4, 0, 1, 0, "R9 zero duty");
        run_pattern(4, 0, 1, P + 1, "R9 R6 full duty");
    endtask

    // R7: enable drop and restart
    task automatic t_enable();
        do_reset(4'b0001, 2'b00, 2'b01);
        @(negedge clk);
        duty = DW'(100);
        en = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(pwm != '0, "R7", "outputs active before drop", int'(pwm), 1);
        en = 1'b0;
        #1;
        check(pwm == '0, "R7", "outputs low when disabled", int'(pwm), 0);
        repeat (4) @(posedge clk);
        run_pattern(2, 0, 1, 100, "R7 restart from zero");
    endtask

    // R1: strap changes after capture are ignored
    task automatic t_strap_hold();
        do_reset(4'b0000, 2'b10, 2'b10);
        @(negedge clk);
        ps = 4'b0001; as = 2'b00; cs = 2'b01;
        check_role(1'b0, "R1");
        run_pattern(6, 3, 4, 25, "R1 straps held");
    endtask

    initial begin
        t_two_phase_master();
        t_priority();
        t_slaves();
        t_duty_limits();
        t_enable();
        t_strap_hold();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule